// File: doc/BRIEF.md
# Five-Counter Timer Host Command Front End

This block sits between a host bus and a bank of five counters. The host drives it through two ports. A command port takes one byte per cycle. A data port moves 16-bit words to and from counter registers. Each command byte holds an opcode and its target together. The target is either a five-bit mask of counters or a single counter number. The block turns each command into per-counter strobes and state changes: arm, disarm, load, save, step, and setting or clearing a toggle output. A group of special bytes resets the whole block and chooses between an 8-bit and a 16-bit data path.

A five-bit data pointer decides which register the data port reaches. It can point at the mode, load or hold element of one counter, at the global mode register, or at a read-only status word. Each data transfer on a counter element moves the pointer on to the next element of the same counter, so one pointer command followed by three writes fills mode, load and hold. The counting logic is outside this block. The block presents the stored mode, load and hold words to it and takes in the live count of each counter, which a save copies into that counter's hold register.

Top module: `timer_cmd_if`

## Requirements
- R1: After reset, `armed`, `tog_out`, `bus_wide`, `master_mode` and every mode, load and hold register are zero, and the pointer selects counter 1's mode element, so a read returns 0.
- R2: A mask command applies to counter n+1 when bit n of cmd_byte[4:0] is set. Opcode bits 7:5 = 001 sets those `armed` bits and 011 also sets them, and both raise `arm_pulse` for those counters in the command cycle. Bits 7:5 = 110 and 100 clear them.
- R3: Bits 7:5 = 010 or 011 raise `load_pulse` for the masked counters, in the command cycle only.
- R4: Bits 7:5 = 101 or 100 copy each masked counter's `live_count` slice into its hold register at the next edge. If a data write aims at the same hold register in that cycle, the save wins.
- R5: Byte 0xE0+n clears and byte 0xE8+n sets `tog_out[n-1]`, for n from 1 to 5.
- R6: Byte 0xF0+n (n from 1 to 5) raises `step_pulse[n-1]` for the command cycle only.
- R7: A byte with bits 7:5 = 000, element code e in bits 4:3 (0 mode, 1 load, 2 hold) and counter n (1 to 5) in bits 2:0 loads the pointer. Each data write or read acknowledge on a counter element moves the pointer mode→load→hold→mode within that counter.
- R8: Pointer 0x17 reaches `master_mode` and pointer 0x1F reads status, with `tog_out` in bits 4:0 and zeros above. Writes to status are dropped. Neither pointer advances on transfers.
- R9: Byte 0xEF selects the 16-bit path and 0xE7 the 8-bit path. On the 8-bit path a write stores data bits 7:0 with the upper byte zero, and `rd_data` shows only bits 7:0.
- R10: Byte 0xFF returns the block to the R1 state at the next edge, and it overrides a data write in the same cycle.
- R11: Undefined bytes change nothing. These include pointer loads with counter 0, 6 or 7 other than 0x17, element code 3 other than 0x1F, 0xE6, 0xEE, 0xF8 to 0xFE, and 0xE0, 0xE8 or 0xF0 with counter number 0.
- R12: When a command and a data transfer share a cycle, the transfer uses the pointer as it stood before the command. A pointer-load command in that cycle sets the pointer without the advance.
- R13: `rd_data` always shows the selected register, and `rd_ack` consumes that word and advances the pointer as a write would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_byte | input | 8 | Command byte |
| wr_valid | input | 1 | Data write this cycle |
| wr_data | input | 16 | Data write word |
| rd_ack | input | 1 | Host consumes `rd_data` this cycle |
| rd_data | output | 16 | Register selected by the pointer |
| live_count | input | 80 | Live count of each counter, counter 1 in the low slice |
| arm_pulse | output | 5 | Per-counter arm strobe |
| load_pulse | output | 5 | Per-counter load strobe |
| step_pulse | output | 5 | Per-counter single-step strobe |
| armed | output | 5 | Per-counter armed state |
| tog_out | output | 5 | Per-counter toggle output level |
| bus_wide | output | 1 | 1 when the 16-bit data path is selected |
| master_mode | output | 16 | Global mode register |
| mode_regs | output | 80 | Mode words, counter 1 in the low slice |
| load_regs | output | 80 | Load words, counter 1 in the low slice |
| hold_regs | output | 80 | Hold words, counter 1 in the low slice |

## Verification
The command path and the data path act in the same cycle when `cmd_valid` and `wr_valid` are both high, and two such collisions are set up on purpose. In the first, the pointer sits on counter 2's hold element while a save for counter 2 and a data write arrive together. The hold register must then show the live count and not the written word. In the second, a pointer-load command lands in the same cycle as a write. The written word must appear in the element the old pointer named, and the next read must come from the new pointer's element with no advance.

// File: rtl/timer_cmd_pkg.sv
// Shared constants and the decoded-command record for the timer front end.
// Assumes five counters; the mask field of a command byte is five bits wide.
package timer_cmd_pkg;
    localparam int NCTR = 5;
    localparam logic [4:0] PTR_MASTER = 5'h17;
    localparam logic [4:0] PTR_STATUS = 5'h1F;
    localparam logic [4:0] PTR_RESET  = 5'h01;

    typedef enum logic [1:0] {
        EL_MODE = 2'd0,
        EL_LOAD = 2'd1,
        EL_HOLD = 2'd2,
        EL_SPEC = 2'd3
    } elem_e;

    typedef struct packed {
        logic [NCTR-1:0] arm;
        logic [NCTR-1:0] load;
        logic [NCTR-1:0] save;
        logic [NCTR-1:0] disarm;
        logic [NCTR-1:0] tog_clr;
        logic [NCTR-1:0] tog_set;
        logic [NCTR-1:0] step;
        logic            ptr_ld;
        logic [4:0]      ptr_val;
        logic            go_wide;
        logic            go_narrow;
        logic            mreset;
    } cmd_t;
endpackage

// File: rtl/timer_cmd_decode.sv
// Command byte decoder: turns one byte into per-counter actions.
// Purely combinational; undefined bytes decode to all-zero actions.
module timer_cmd_decode
    import timer_cmd_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    output cmd_t       cmd
);
    logic [2:0]      num;
    logic            num_ok;
    logic [NCTR-1:0] one_sel;
    logic [NCTR-1:0] mask;
    logic            ptr_ok;

    // Field extraction shared by every opcode group.
    always_comb begin
        num     = cmd_byte[2:0];
        num_ok  = (num >= 3'd1) && (num <= 3'(NCTR));
        one_sel = num_ok ? (NCTR'(1) << (num - 3'd1)) : '0;
        mask    = cmd_byte[NCTR-1:0];
        ptr_ok  = ((cmd_byte[4:3] != EL_SPEC) && num_ok)
                  || (cmd_byte[4:0] == PTR_MASTER)
                  || (cmd_byte[4:0] == PTR_STATUS);
    end

    // Opcode dispatch on bits 7:5, then on the full byte for the special group.
    always_comb begin
        cmd = '0;
        if (cmd_valid) begin
            case (cmd_byte[7:5])
                3'b000: if (ptr_ok) begin
                    cmd.ptr_ld  = 1'b1;
                    cmd.ptr_val = cmd_byte[4:0];
                end
                3'b001: cmd.arm = mask;
                3'b010: cmd.load = mask;
                3'b011: begin cmd.load = mask; cmd.arm = mask; end
                3'b100: begin cmd.disarm = mask; cmd.save = mask; end
                3'b101: cmd.save = mask;
                3'b110: cmd.disarm = mask;
                default: begin
                    if (cmd_byte == 8'hFF)      cmd.mreset    = 1'b1;
                    else if (cmd_byte == 8'hEF) cmd.go_wide   = 1'b1;
                    else if (cmd_byte == 8'hE7) cmd.go_narrow = 1'b1;
                    else begin
                        case (cmd_byte[4:3])
                            2'b00:   cmd.tog_clr = one_sel;
                            2'b01:   cmd.tog_set = one_sel;
                            2'b10:   cmd.step    = one_sel;
                            default: ;
                        endcase
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/timer_ptr_unit.sv
// Data pointer: loaded by command, stepped by data transfers.
// Assumes a load has priority over a step; special pointers never step.
module timer_ptr_unit
    import timer_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mreset,
    input  logic       ptr_ld,
    input  logic [4:0] ptr_val,
    input  logic       xfer,
    output logic [4:0] ptr
);
    logic       on_elem;
    logic [1:0] next_el;

    // Decide whether the pointer names a counter element and what follows it.
    always_comb begin
        on_elem = (ptr[4:3] != EL_SPEC) && (ptr[2:0] >= 3'd1) && (ptr[2:0] <= 3'(NCTR));
        next_el = (ptr[4:3] == EL_HOLD) ? EL_MODE : (ptr[4:3] + 2'd1);
    end

    // Pointer register with reset, load and wrap-around advance.
    always_ff @(posedge clk) begin
        if (!rst_n || mreset)     ptr <= PTR_RESET;
        else if (ptr_ld)          ptr <= ptr_val;
        else if (xfer && on_elem) ptr <= {next_el, ptr[2:0]};
    end
endmodule

// File: rtl/timer_reg_bank.sv
// Per-counter mode, load and hold words plus the global mode word.
// Assumes a save beats a data write to the same hold word.
module timer_reg_bank
    import timer_cmd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mreset,
    input  logic [4:0]      ptr,
    input  logic            wr_valid,
    input  logic [W-1:0]    wr_data,
    input  logic            bus_wide,
    input  logic [NCTR-1:0] save,
    input  logic [NCTR*W-1:0] live_count,
    input  logic [NCTR-1:0] status_bits,
    output logic [W-1:0]    rd_data,
    output logic [W-1:0]    master_q,
    output logic [NCTR*W-1:0] mode_flat,
    output logic [NCTR*W-1:0] load_flat,
    output logic [NCTR*W-1:0] hold_flat
);
    localparam int NARROW = 8;
    localparam logic [W-1:0] LOW_MASK = W'((1 << NARROW) - 1);

    logic [W-1:0] wdat;
    logic [W-1:0] rd_raw;
    logic [W-1:0] mode_q [NCTR];
    logic [W-1:0] load_q [NCTR];
    logic [W-1:0] hold_q [NCTR];

    // Narrow the write word when the 8-bit path is selected.
    always_comb wdat = bus_wide ? wr_data : (wr_data & LOW_MASK);

    // Global mode word.
    always_ff @(posedge clk) begin
        if (!rst_n || mreset)                    master_q <= '0;
        else if (wr_valid && ptr == PTR_MASTER)  master_q <= wdat;
    end

    for (genvar k = 0; k < NCTR; k++) begin : g_ctr
        logic hit;
        always_comb hit = wr_valid && (ptr[2:0] == 3'(k + 1));

        // Element storage for one counter; save overrides a hold write.
        always_ff @(posedge clk) begin
            if (!rst_n || mreset) begin
                mode_q[k] <= '0;
                load_q[k] <= '0;
                hold_q[k] <= '0;
            end else begin
                if (hit && ptr[4:3] == EL_MODE) mode_q[k] <= wdat;
                if (hit && ptr[4:3] == EL_LOAD) load_q[k] <= wdat;
                if (save[k])                    hold_q[k] <= live_count[k*W +: W];
                else if (hit && ptr[4:3] == EL_HOLD) hold_q[k] <= wdat;
            end
        end

        assign mode_flat[k*W +: W] = mode_q[k];
        assign load_flat[k*W +: W] = load_q[k];
        assign hold_flat[k*W +: W] = hold_q[k];
    end

    // Read multiplexer following the pointer, masked on the 8-bit path.
    always_comb begin
        rd_raw = '0;
        if (ptr == PTR_MASTER)      rd_raw = master_q;
        else if (ptr == PTR_STATUS) rd_raw = W'(status_bits);
        else begin
            for (int k = 0; k < NCTR; k++) begin
                if (ptr[2:0] == 3'(k + 1)) begin
                    case (ptr[4:3])
                        EL_MODE: rd_raw = mode_q[k];
                        EL_LOAD: rd_raw = load_q[k];
                        EL_HOLD: rd_raw = hold_q[k];
                        default: ;
                    endcase
                end
            end
        end
        rd_data = bus_wide ? rd_raw : (rd_raw & LOW_MASK);
    end
endmodule

// File: rtl/timer_cmd_if.sv
// Host front end for five counters: command decode, pointer, registers,
// armed and toggle state, bus width. Counting itself lives elsewhere.
module timer_cmd_if
    import timer_cmd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    input  logic              wr_valid,
    input  logic [W-1:0]      wr_data,
    input  logic              rd_ack,
    output logic [W-1:0]      rd_data,
    input  logic [NCTR*W-1:0] live_count,
    output logic [NCTR-1:0]   arm_pulse,
    output logic [NCTR-1:0]   load_pulse,
    output logic [NCTR-1:0]   step_pulse,
    output logic [NCTR-1:0]   armed,
    output logic [NCTR-1:0]   tog_out,
    output logic              bus_wide,
    output logic [W-1:0]      master_mode,
    output logic [NCTR*W-1:0] mode_regs,
    output logic [NCTR*W-1:0] load_regs,
    output logic [NCTR*W-1:0] hold_regs
);
    cmd_t       cmd;
    logic [4:0] ptr;

    timer_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .cmd       (cmd)
    );

    timer_ptr_unit u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .mreset  (cmd.mreset),
        .ptr_ld  (cmd.ptr_ld),
        .ptr_val (cmd.ptr_val),
        .xfer    (wr_valid || rd_ack),
        .ptr     (ptr)
    );

    timer_reg_bank #(.W(W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .mreset      (cmd.mreset),
        .ptr         (ptr),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .bus_wide    (bus_wide),
        .save        (cmd.save),
        .live_count  (live_count),
        .status_bits (tog_out),
        .rd_data     (rd_data),
        .master_q    (master_mode),
        .mode_flat   (mode_regs),
        .load_flat   (load_regs),
        .hold_flat   (hold_regs)
    );

    // Strobes go out in the command cycle itself.
    assign arm_pulse  = cmd.arm;
    assign load_pulse = cmd.load;
    assign step_pulse = cmd.step;

    // Armed, toggle and bus-width state.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd.mreset) begin
            armed    <= '0;
            tog_out  <= '0;
            bus_wide <= 1'b0;
        end else begin
            armed   <= (armed & ~cmd.disarm) | cmd.arm;
            tog_out <= (tog_out & ~cmd.tog_clr) | cmd.tog_set;
            if (cmd.go_wide)        bus_wide <= 1'b1;
            else if (cmd.go_narrow) bus_wide <= 1'b0;
        end
    end
endmodule

// File: rtl/timer_cmd_if_checker.sv
// Temporal checks on the front end's ports, bound to every instance.
module timer_cmd_if_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [7:0] cmd_byte,
    input logic [4:0] arm_pulse,
    input logic [4:0] load_pulse,
    input logic [4:0] step_pulse,
    input logic [4:0] armed,
    input logic [4:0] tog_out,
    input logic       bus_wide
);
    assert_arm_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[7:5] == 3'b001)
        |=> ((armed & $past(cmd_byte[4:0])) == $past(cmd_byte[4:0])));

    assert_disarm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[7:5] == 3'b110) |=> ((armed & $past(cmd_byte[4:0])) == 5'd0));

    assert_strobes_need_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse != 5'd0 || arm_pulse != 5'd0) |-> cmd_valid);

    assert_toggle_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[7:3] == 5'b11101 && cmd_byte[2:0] >= 3'd1 && cmd_byte[2:0] <= 3'd5)
        |=> tog_out[$past(cmd_byte[2:0]) - 3'd1]);

    assert_step_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_pulse));

    assert_wide_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte == 8'hEF) |=> bus_wide);

    assert_master_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte == 8'hFF) |=> (armed == 5'd0 && tog_out == 5'd0 && !bus_wide));
endmodule

bind timer_cmd_if timer_cmd_if_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_byte   (cmd_byte),
    .arm_pulse  (arm_pulse),
    .load_pulse (load_pulse),
    .step_pulse (step_pulse),
    .armed      (armed),
    .tog_out    (tog_out),
    .bus_wide   (bus_wide)
);

// File: tb/timer_cmd_if_bench.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares them.
module timer_cmd_if_bench;
    localparam int W = 16;
    localparam int N = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic [7:0]     cmd_byte = '0;
    logic           wr_valid = 1'b0;
    logic [W-1:0]   wr_data = '0;
    logic           rd_ack = 1'b0;
    logic [W-1:0]   rd_data;
    logic [N*W-1:0] live_count;
    logic [N-1:0]   arm_pulse, load_pulse, step_pulse, armed, tog_out;
    logic           bus_wide;
    logic [W-1:0]   master_mode;
    logic [N*W-1:0] mode_regs, load_regs, hold_regs;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    logic [W-1:0] exp_q [$];
    string        tag_q [$];
    logic [N-1:0] cap_arm, cap_load, cap_step;

    timer_cmd_if #(.W(W)) u_timer_cmd_if (.*);

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    // Monitor: compare each acknowledged read with the queued expectation.
    always @(negedge clk) begin
        if (rd_ack) begin
            if (exp_q.size() == 0) check("R13 unexpected read", rd_data, 'x);
            else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    // One cycle of stimulus, entered just after an edge; captures strobes mid-cycle.
    task automatic drive(input bit cv, input logic [7:0] cb, input bit wv,
                         input logic [W-1:0] wd, input bit ra);
        cmd_valid = cv; cmd_byte = cb; wr_valid = wv; wr_data = wd; rd_ack = ra;
        @(negedge clk);
        cap_arm = arm_pulse; cap_load = load_pulse; cap_step = step_pulse;
        @(posedge clk); #1;
        cmd_valid = 0; wr_valid = 0; rd_ack = 0;
    endtask

    task automatic cmd(input logic [7:0] b);
        drive(1, b, 0, '0, 0);
    endtask

    task automatic wr(input logic [W-1:0] d);
        drive(0, 8'h00, 1, d, 0);
    endtask

    task automatic rd(input logic [W-1:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        drive(0, 8'h00, 0, '0, 1);
    endtask

    function automatic logic [W-1:0] slice(input logic [N*W-1:0] v, input int ctr);
        return v[(ctr-1)*W +: W];
    endfunction

    initial begin
        #4_000_000;
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) live_count[i*W +: W] = 16'hC000 + 16'(i);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check("R1 armed", W'(armed), 0);
        check("R1 tog", W'(tog_out), 0);
        check("R1 bus", W'(bus_wide), 0);
        check("R1 master", master_mode, 0);
        rd(16'h0000, "R1 first read");

        // R9 wide path, R7 pointer and wrap
        cmd(8'hEF);
        check("R9 wide", W'(bus_wide), 1);
        cmd(8'h02);
        wr(16'h1234); wr(16'h5678); wr(16'h9ABC); wr(16'h1111);
        check("R7 mode2 after wrap", slice(mode_regs, 2), 16'h1111);
        check("R7 load2", slice(load_regs, 2), 16'h5678);
        check("R7 hold2", slice(hold_regs, 2), 16'h9ABC);
        cmd(8'h02);
        rd(16'h1111, "R13 read mode2");
        rd(16'h5678, "R13 read load2");
        rd(16'h9ABC, "R13 read hold2");
        rd(16'h1111, "R7 read wraps to mode2");
        cmd(8'h0B);
        wr(16'h00AA);
        check("R7 load3 direct", slice(load_regs, 3), 16'h00AA);

        // R8 master and status
        cmd(8'h17);
        wr(16'hBEEF); wr(16'h0123);
        check("R8 master no advance", master_mode, 16'h0123);
        rd(16'h0123, "R8 master read");
        cmd(8'hE9); cmd(8'hEB);
        check("R5 set tog", W'(tog_out), 16'h0005);
        cmd(8'h1F);
        rd(16'h0005, "R8 status read");
        wr(16'hFFFF);
        check("R8 status write dropped", master_mode, 16'h0123);
        rd(16'h0005, "R8 status again");

        // R2/R3 mask commands
        cmd(8'h25);
        check("R2 arm pulse", W'(cap_arm), 16'h0005);
        check("R2 armed", W'(armed), 16'h0005);
        cmd(8'hC4);
        check("R2 disarm", W'(armed), 16'h0001);
        cmd(8'h72);
        check("R3 load pulse", W'(cap_load), 16'h0012);
        check("R2 loadarm pulse", W'(cap_arm), 16'h0012);
        check("R2 armed after loadarm", W'(armed), 16'h0013);
        cmd(8'h20);
        check("R3 no load on arm", W'(cap_load), 0);

        // R4 save
        cmd(8'hA2);
        check("R4 save hold2", slice(hold_regs, 2), 16'hC001);
        cmd(8'h81);
        check("R4 disarm-save hold1", slice(hold_regs, 1), 16'hC000);
        check("R2 disarm-save armed", W'(armed), 16'h0012);

        // R6 step, R5 clear
        cmd(8'hF4);
        check("R6 step4", W'(cap_step), 16'h0008);
        cmd(8'hF0);
        check("R11 step n=0 ignored", W'(cap_step), 0);
        cmd(8'hE1);
        check("R5 clear tog1", W'(tog_out), 16'h0004);

        // R11 undefined bytes
        cmd(8'h12);
        cmd(8'h06); cmd(8'h18); cmd(8'h1A); cmd(8'hE6); cmd(8'hEE); cmd(8'hF8); cmd(8'hE8); cmd(8'hE0);
        check("R11 armed kept", W'(armed), 16'h0012);
        check("R11 tog kept", W'(tog_out), 16'h0004);
        check("R11 bus kept", W'(bus_wide), 1);
        rd(16'hC001, "R11 pointer kept");

        // R12/R4 collisions
        live_count[1*W +: W] = 16'hD002;
        cmd(8'h12);
        drive(1, 8'hA2, 1, 16'h5555, 0);
        check("R4 save beats write", slice(hold_regs, 2), 16'hD002);
        drive(1, 8'h03, 1, 16'h7777, 0);
        check("R12 write used old ptr", slice(mode_regs, 2), 16'h7777);
        rd(16'h0000, "R12 new ptr no advance");

        // R9 narrow path
        cmd(8'hE7);
        check("R9 narrow", W'(bus_wide), 0);
        cmd(8'h04);
        wr(16'hABCD);
        check("R9 narrow write", slice(mode_regs, 4), 16'h00CD);
        cmd(8'h0A);
        rd(16'h0078, "R9 narrow read");

        // R10 master reset, also beating a same-cycle write
        cmd(8'h17);
        drive(1, 8'hFF, 1, 16'h4242, 0);
        check("R10 armed", W'(armed), 0);
        check("R10 tog", W'(tog_out), 0);
        check("R10 master", master_mode, 0);
        check("R10 regs", slice(load_regs, 2), 0);
        rd(16'h0000, "R10 ptr at mode1");

        repeat (2) @(posedge clk);
        check("R13 queue drained", W'(exp_q.size()), 0);
        finish_run();
    end
endmodule